// File: doc/BRIEF.md
# Parallel Flash Host Bus Front End

This block sits between the external pins of a parallel NOR-style flash device and its internal logic, and runs on the device's own system clock. Four active-low control pins (chip select, output enable, write strobe and a hardware reset) pass through synchronisers. The block then decodes them into one of five bus modes, reported on a 3-bit status output. Only in the read mode does it enable the 16-bit data drivers, and then it passes the word supplied by the array side.

A write cycle runs while chip select and write strobe are both low. It ends on whichever of the two rises first. The address and data present at that moment are handed to a downstream command interpreter as a single-cycle strobe. Writes never address memory storage; each captured pair is a command. Holding the reset pin low abandons any unfinished write, so no strobe is produced for it.

Top module: `flash_bus_front`

## Requirements
- R1: While the reset pin is low, the mode output reads 4 (reset) and the data drivers are disabled, whatever the other pins are.
- R2: With reset high and chip select high, the mode reads 0 (standby) and the data drivers are off; output enable and write strobe have no effect.
- R3: With chip select and output enable low and write strobe and reset high, the mode reads 1 (read), `rd_drive_en` is 1 and `rd_data_o` equals `array_rdata`.
- R4: In every mode other than read, `rd_drive_en` is 0 and `rd_data_o` is all zeros.
- R5: With chip select and write strobe low and output enable and reset high, the mode reads 2 (write) and the data bus is only an input.
- R6: With reset high, chip select low and output enable high, and no write under way, the mode reads 3 (output disabled). The same mode applies when output enable and write strobe are both low and no write is under way.
- R7: A write ends when the write strobe rises. Exactly one cycle of `cmd_valid` follows, three clocks after the rising edge is sampled. It carries the address and data that were present just before the edge, even if both change together with it.
- R8: A write ends and strobes when chip select rises first. Afterwards a new write starts only once the write strobe has been seen high and then low again.
- R9: When chip select and write strobe rise in the same sampled clock, exactly one strobe is produced.
- R10: A low reset pin cancels a write in progress, and no strobe follows, even when reset falls in the same sampled clock as the write strobe rises.
- R11: In the first synchronised cycle after the reset pin returns high, the mode reads standby. Decoding resumes on the next cycle.
- R12: Once a write is under way, lowering output enable neither ends it nor enables the data drivers. The mode stays write until chip select or write strobe rises.
- R13: Mode changes on the pins appear on the mode output two clocks after they are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the logic |
| chip_sel_n | input | 1 | Chip select pin, active low |
| out_en_n | input | 1 | Output enable pin, active low |
| wr_strobe_n | input | 1 | Write strobe pin, active low |
| pin_rst_n | input | 1 | Hardware reset pin, active low |
| bus_addr | input | AW (20) | Address pins |
| bus_wdata | input | DW (16) | Inbound data bus |
| array_rdata | input | DW (16) | Read word from the array side |
| rd_data_o | output | DW (16) | Outbound data word, zero when not driving |
| rd_drive_en | output | 1 | Tri-state enable for the data bus |
| mode | output | 3 | 0 standby, 1 read, 2 write, 3 output disabled, 4 reset |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_addr | output | AW (20) | Address captured at write end |
| cmd_data | output | DW (16) | Data captured at write end |

## Verification
The end of a write and the hardware reset can land in the same sampled clock. The bench provokes this by lowering the reset pin on the same clock edge as the write strobe rises, then counts strobes over several following cycles and expects none, with the mode at reset. The second collision is chip select and write strobe rising together. That case is judged by the strobe count staying at exactly one, and by the next write being accepted without a fresh high level on the write strobe.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

    localparam int FBF_MODE_W = 3;

    typedef enum logic [FBF_MODE_W-1:0] {
        FBF_STANDBY = 3'd0,
        FBF_READ    = 3'd1,
        FBF_WRITE   = 3'd2,
        FBF_OUTDIS  = 3'd3,
        FBF_RESET   = 3'd4
    } fbf_mode_e;

    // control pins, all active low
    typedef struct packed {
        logic sel_n;
        logic oen_n;
        logic wen_n;
        logic rst_n;
    } fbf_pins_t;

    localparam int FBF_PINS_W = $bits(fbf_pins_t);

    // mode decode; reset pin dominates, then select, then write tracking
    function automatic fbf_mode_e fbf_decode(
        input fbf_pins_t p,
        input logic      armed,
        input logic      rearm_wait,
        input logic      settle
    );
        fbf_mode_e m;
        if (!p.rst_n)
            m = FBF_RESET;
        else if (settle || p.sel_n)
            m = FBF_STANDBY;
        else if (!p.wen_n && (armed || (p.oen_n && !rearm_wait)))
            m = FBF_WRITE;
        else if (!p.oen_n && p.wen_n)
            m = FBF_READ;
        else
            m = FBF_OUTDIS;
        return m;
    endfunction

endpackage

// File: rtl/fbf_sync.sv
module fbf_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= RST_VAL;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fbf_mode_decode.sv
module fbf_mode_decode
    import fbf_pkg::*;
(
    input  fbf_pins_t pins,
    input  logic      armed,
    input  logic      rearm_wait,
    input  logic      settle,
    output fbf_mode_e mode,
    output logic      wr_end
);
    always_comb begin
        mode   = fbf_decode(pins, armed, rearm_wait, settle);
        // a write ends when select or strobe is seen high with reset released
        wr_end = armed && pins.rst_n && (pins.sel_n || pins.wen_n);
    end
endmodule

// File: rtl/fbf_write_track.sv
module fbf_write_track
    import fbf_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  fbf_pins_t     pins,
    input  fbf_mode_e     mode,
    input  logic          wr_end,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          armed,
    output logic          rearm_wait,
    output logic          settle,
    output logic          cmd_valid,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_data
);
    logic          rst_pin_prev;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;

    assign settle = !rst_pin_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_pin_prev <= 1'b1;
            armed        <= 1'b0;
            rearm_wait   <= 1'b0;
            hold_addr    <= '0;
            hold_data    <= '0;
            cmd_valid    <= 1'b0;
            cmd_addr     <= '0;
            cmd_data     <= '0;
        end else begin
            rst_pin_prev <= pins.rst_n;
            cmd_valid    <= 1'b0;
            if (!pins.rst_n) begin
                armed      <= 1'b0;
                rearm_wait <= 1'b0;
            end else begin
                if (wr_end) begin
                    cmd_valid <= 1'b1;
                    cmd_addr  <= hold_addr;
                    cmd_data  <= hold_data;
                    armed     <= 1'b0;
                end else if (mode == FBF_WRITE) begin
                    armed     <= 1'b1;
                    hold_addr <= addr_s;
                    hold_data <= data_s;
                end
                if (wr_end)
                    rearm_wait <= !pins.wen_n;
                else if (pins.wen_n)
                    rearm_wait <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
    import fbf_pkg::*;
#(
    parameter int AW          = 20,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chip_sel_n,
    input  logic          out_en_n,
    input  logic          wr_strobe_n,
    input  logic          pin_rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] array_rdata,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_drive_en,
    output logic [2:0]    mode,
    output logic          cmd_valid,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_data
);
    localparam int BUS_W = AW + DW;

    fbf_pins_t      pins_raw, pins_s;
    logic [BUS_W-1:0] bus_s;
    fbf_mode_e      mode_q;
    logic           wr_end, armed, rearm_wait, settle;

    assign pins_raw = '{sel_n: chip_sel_n, oen_n: out_en_n,
                        wen_n: wr_strobe_n, rst_n: pin_rst_n};

    fbf_sync #(.W(FBF_PINS_W), .STAGES(SYNC_STAGES), .RST_VAL({FBF_PINS_W{1'b1}}))
        u_pin_sync (.clk(clk), .rst(rst), .d(pins_raw), .q(pins_s));

    // same depth as the pins so captured values line up with detected edges
    fbf_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0))
        u_bus_sync (.clk(clk), .rst(rst), .d({bus_addr, bus_wdata}), .q(bus_s));

    fbf_mode_decode u_decode (
        .pins(pins_s), .armed(armed), .rearm_wait(rearm_wait),
        .settle(settle), .mode(mode_q), .wr_end(wr_end)
    );

    fbf_write_track #(.AW(AW), .DW(DW)) u_track (
        .clk(clk), .rst(rst), .pins(pins_s), .mode(mode_q), .wr_end(wr_end),
        .addr_s(bus_s[BUS_W-1:DW]), .data_s(bus_s[DW-1:0]),
        .armed(armed), .rearm_wait(rearm_wait), .settle(settle),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    assign mode        = mode_q;
    assign rd_drive_en = (mode_q == FBF_READ);
    assign rd_data_o   = rd_drive_en ? array_rdata : '0;
endmodule

// File: rtl/fbf_checker.sv
module fbf_checker
    import fbf_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode,
    input logic       rd_drive_en,
    input logic       cmd_valid
);
    // R1
    reset_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == FBF_RESET) |-> !rd_drive_en);

    // R2
    standby_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == FBF_STANDBY) |-> !rd_drive_en);

    // R7
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R7
    strobe_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ($past(mode, 2) == FBF_WRITE));

    // R10
    reset_blocks_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == FBF_RESET) |=> !cmd_valid);

    // R11
    release_settle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == FBF_RESET) |=> (mode == FBF_RESET || mode == FBF_STANDBY));
endmodule

bind flash_bus_front fbf_checker u_fbf_checker (
    .clk(clk), .rst(rst), .mode(mode), .rd_drive_en(rd_drive_en), .cmd_valid(cmd_valid)
);

// File: tb/flash_bus_front_bench.sv
module flash_bus_front_bench;
    localparam int AW = 20;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chip_sel_n = 1'b1, out_en_n = 1'b1, wr_strobe_n = 1'b1, pin_rst_n = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] array_rdata = '0;
    logic [DW-1:0] rd_data_o;
    logic          rd_drive_en;
    logic [2:0]    mode;
    logic          cmd_valid;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    bit done = 0;

    always #5 clk = ~clk;

    flash_bus_front #(.AW(AW), .DW(DW)) u_flash_bus_front (
        .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
        .wr_strobe_n(wr_strobe_n), .pin_rst_n(pin_rst_n), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .array_rdata(array_rdata), .rd_data_o(rd_data_o),
        .rd_drive_en(rd_drive_en), .mode(mode), .cmd_valid(cmd_valid),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    always @(negedge clk) if (!rst && cmd_valid) strobes++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(input logic s, input logic o, input logic w, input logic r);
        chip_sel_n = s; out_en_n = o; wr_strobe_n = w; pin_rst_n = r;
    endtask

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic go_idle();
        pins(1, 1, 1, 1);
        tick(4);
        strobes = 0;
    endtask

    task automatic t_reset_state();
        check_eq("R2", "mode after reset", 32'(mode), 0);
        check_eq("R4", "drive after reset", 32'(rd_drive_en), 0);
        check_eq("R7", "no strobe after reset", 32'(cmd_valid), 0);
    endtask

    task automatic t_read_and_outdis();
        go_idle();
        array_rdata = 16'hA5A5;
        pins(0, 0, 1, 1);
        tick(1);
        check_eq("R13", "mode one clock after pins", 32'(mode), 0);
        tick(1);
        check_eq("R3", "read mode", 32'(mode), 1);
        check_eq("R3", "drive enable", 32'(rd_drive_en), 1);
        check_eq("R3", "read word", 32'(rd_data_o), 32'hA5A5);
        array_rdata = 16'h1234;
        #1;
        check_eq("R3", "read word follows array", 32'(rd_data_o), 32'h1234);
        pins(0, 1, 1, 1);
        tick(2);
        check_eq("R6", "output disabled", 32'(mode), 3);
        check_eq("R4", "no drive outdis", 32'(rd_drive_en), 0);
        check_eq("R4", "zero word outdis", 32'(rd_data_o), 0);
        pins(0, 0, 0, 1);
        tick(2);
        check_eq("R6", "oe and we both low", 32'(mode), 3);
        check_eq("R4", "no drive both low", 32'(rd_drive_en), 0);
    endtask

    task automatic t_standby();
        go_idle();
        pins(1, 0, 0, 1);
        tick(3);
        check_eq("R2", "standby ignores oe/we", 32'(mode), 0);
        check_eq("R4", "zero word standby", 32'(rd_data_o), 0);
        check_eq("R2", "no strobe in standby", 32'(strobes), 0);
    endtask

    task automatic t_write_we_end();
        go_idle();
        bus_addr = 20'h12345; bus_wdata = 16'hBEEF;
        pins(0, 1, 0, 1);
        tick(2);
        check_eq("R5", "write mode", 32'(mode), 2);
        check_eq("R4", "no drive in write", 32'(rd_drive_en), 0);
        tick(2);
        pins(0, 1, 1, 1);
        bus_addr = 20'h0AAAA; bus_wdata = 16'h1111;
        tick(2);
        check_eq("R7", "no strobe yet", 32'(cmd_valid), 0);
        tick(1);
        check_eq("R7", "strobe on third clock", 32'(cmd_valid), 1);
        check_eq("R7", "captured address", 32'(cmd_addr), 32'h12345);
        check_eq("R7", "captured data", 32'(cmd_data), 32'hBEEF);
        tick(1);
        check_eq("R7", "strobe one cycle", 32'(cmd_valid), 0);
        tick(3);
        check_eq("R7", "strobe count", 32'(strobes), 1);
        check_eq("R6", "outdis after write", 32'(mode), 3);
    endtask

    task automatic t_write_sel_end();
        go_idle();
        bus_addr = 20'h00F0F; bus_wdata = 16'h5A5A;
        pins(0, 1, 0, 1);
        tick(3);
        pins(1, 1, 0, 1);
        tick(5);
        check_eq("R8", "strobe on select rise", 32'(strobes), 1);
        check_eq("R8", "captured data", 32'(cmd_data), 32'h5A5A);
        pins(0, 1, 0, 1);
        tick(4);
        check_eq("R8", "no write without strobe cycle", 32'(mode), 3);
        check_eq("R8", "no extra strobe", 32'(strobes), 1);
        pins(0, 1, 1, 1);
        tick(3);
        pins(0, 1, 0, 1);
        tick(2);
        check_eq("R8", "write after strobe cycled", 32'(mode), 2);
        pins(0, 1, 1, 1);
        tick(5);
        check_eq("R8", "second strobe", 32'(strobes), 2);
    endtask

    task automatic t_simultaneous();
        go_idle();
        bus_addr = 20'h77777; bus_wdata = 16'hC0DE;
        pins(0, 1, 0, 1);
        tick(3);
        pins(1, 1, 1, 1);
        tick(6);
        check_eq("R9", "one strobe on joint rise", 32'(strobes), 1);
        check_eq("R9", "captured address", 32'(cmd_addr), 32'h77777);
        pins(0, 1, 0, 1);
        tick(2);
        check_eq("R9", "next write accepted", 32'(mode), 2);
        pins(1, 1, 1, 1);
        tick(5);
        check_eq("R9", "next write strobes", 32'(strobes), 2);
    endtask

    task automatic t_reset_abort();
        go_idle();
        pins(0, 1, 0, 1);
        tick(3);
        pins(0, 1, 1, 0);
        tick(2);
        check_eq("R1", "reset mode", 32'(mode), 4);
        tick(4);
        check_eq("R10", "no strobe with reset", 32'(strobes), 0);
        pins(0, 0, 1, 0);
        tick(2);
        check_eq("R1", "reset over read pins", 32'(mode), 4);
        check_eq("R1", "no drive in reset", 32'(rd_drive_en), 0);
        pins(0, 0, 1, 1);
        tick(2);
        check_eq("R11", "standby on release", 32'(mode), 0);
        tick(1);
        check_eq("R11", "read after settle", 32'(mode), 1);
        go_idle();
        pins(0, 1, 0, 1);
        tick(3);
        pins(0, 1, 0, 0);
        tick(3);
        pins(1, 1, 1, 1);
        tick(6);
        check_eq("R10", "write cleared by reset", 32'(strobes), 0);
    endtask

    task automatic t_oe_in_write();
        go_idle();
        bus_addr = 20'h00001; bus_wdata = 16'h0042;
        pins(0, 1, 0, 1);
        tick(3);
        pins(0, 0, 0, 1);
        tick(3);
        check_eq("R12", "still write with oe low", 32'(mode), 2);
        check_eq("R12", "no drive mid write", 32'(rd_drive_en), 0);
        check_eq("R12", "no strobe mid write", 32'(strobes), 0);
        pins(0, 0, 1, 1);
        tick(5);
        check_eq("R12", "strobe after strobe rise", 32'(strobes), 1);
        check_eq("R12", "captured data", 32'(cmd_data), 32'h0042);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        t_reset_state();
        t_read_and_outdis();
        t_standby();
        t_write_we_end();
        t_write_sel_end();
        t_simultaneous();
        t_reset_abort();
        t_oe_in_write();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule